// File: doc/BRIEF.md
# Multi-Mode Prioritized Interrupt Controller

This block gathers seventeen interrupt sources into two active-low requests for a processor: a normal request (`irq_n`) and a fast request (`fiq_n`). The sources are ten peripheral lines, one external pin and a six-line bus from user logic. Software enables and disables sources through separate set and clear registers. It can read every source before and after the enable mask. Each source has its own priority register. A separate identity register reports the priority of the current winner of normal-request arbitration.

A mode register sets how the six-line user bus is read. In the default mode each line is a source of its own. In the encoded mode the whole bus carries one priority value from user logic. In the split mode the upper five lines carry an even priority value and line 0 remains a source of its own. In the two encoded modes the enable, status and priority settings of the user lines that carry the code have no effect.

The register port is a plain single-cycle write strobe with a word address, and the read data is combinational. The identity register and both requests are registered, so they follow a change at the inputs one clock later.

Top module: `irq_merge_ctrl`

## Requirements
- R1: After reset `irq_n` and `fiq_n` are 1. Mode (address 0x00), the enable mask (0x01) and identity (0x05) read 0, and every priority register reads 0.
- R2: Writing to 0x01 sets each mask bit whose data bit is 1. Writing to 0x02 clears each mask bit whose data bit is 1. Zero data bits leave the mask unchanged, and a read at either address returns the mask.
- R3: Address 0x03 returns the source lines before masking and 0x04 returns them after masking. User lines sit at bits 5:0, the external pin at bit 6 and peripheral lines 9:0 at bits 16:7. The enable mask uses the same bit positions.
- R4: The priority register of source i sits at address 0x08+i. Bits 5:0 hold its level and bit 6 is the fast flag.
- R5: Identity holds the largest level among the pending (enabled, active) sources whose fast flag is 0, and `irq_n` is 0 exactly when that value is nonzero.
- R6: A pending source with level 0 and the fast flag 0 never asserts `irq_n` and never changes identity.
- R7: `fiq_n` is 0 while any pending source has its fast flag set. Such a source has no effect on identity or `irq_n`.
- R8: Mode code 0 reads the user lines individually, code 1 is the six-bit encoded mode, code 2 is the split mode, and code 3 behaves as code 0.
- R9: In mode 1 a nonzero bus value takes part in arbitration with that value as its level, whatever the mask. Status bits 5:0 read 0, and the user lines' mask and priority settings have no effect.
- R10: In mode 2 the value {bus[5:1],0} takes part in arbitration, unmasked. Line 0 remains an individual source, and status bits 5:1 read 0.
- R11: `irq_n`, `fiq_n` and identity reflect the inputs and registers as they stood before the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| periph_irq | input | 10 | Peripheral interrupt lines, active high |
| ext_irq | input | 1 | External pin interrupt, active high |
| user_irq | input | 6 | User-logic interrupt bus |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 17 | Register write data |
| bus_rdata | output | 17 | Register read data |
| irq_n | output | 1 | Normal interrupt request, active low |
| fiq_n | output | 1 | Fast interrupt request, active low |

## Verification
Each kind of fault inside the controller shows at the ports one clock after the stimulus that exposes it.
- A bad mask bit appears in the enable readback in the cycle after the write. It also appears in the pending status, and through that in the identity value.
- A wrong mode decode shows as user-line status bits that should read zero, or as an encoded level that is missing from identity.
- A source sent to the wrong request line shows as `fiq_n` and `irq_n` disagreeing with the fast flag the bench programmed.
- A broken maximum search shows as an identity value below the largest pending level.

// File: rtl/irq_merge_ctrl.sv
module irq_merge_ctrl #(
  parameter int N_PERIPH = 10,
  parameter int N_USER   = 6,
  parameter int ADDR_W   = 5
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [N_PERIPH-1:0]                 periph_irq,
  input  logic                                ext_irq,
  input  logic [N_USER-1:0]                   user_irq,
  input  logic                                bus_we,
  input  logic [ADDR_W-1:0]                   bus_addr,
  input  logic [N_PERIPH+N_USER:0]            bus_wdata,
  output logic [N_PERIPH+N_USER:0]            bus_rdata,
  output logic                                irq_n,
  output logic                                fiq_n
);

  localparam int NSRC = N_PERIPH + N_USER + 1;
  localparam int LVL_W = N_USER;
  localparam int PRIO_W = LVL_W + 1;

  localparam logic [ADDR_W-1:0] A_MODE = 5'h00;
  localparam logic [ADDR_W-1:0] A_SET  = 5'h01;
  localparam logic [ADDR_W-1:0] A_CLR  = 5'h02;
  localparam logic [ADDR_W-1:0] A_RAW  = 5'h03;
  localparam logic [ADDR_W-1:0] A_PEND = 5'h04;
  localparam logic [ADDR_W-1:0] A_ID   = 5'h05;
  localparam int PRIO_BASE = 8;

  localparam logic [1:0] M_INDIV = 2'd0;
  localparam logic [1:0] M_ENC6  = 2'd1;
  localparam logic [1:0] M_ENC5  = 2'd2;

  logic [1:0]                  mode_q;
  logic [NSRC-1:0]             mask_q;
  logic [NSRC-1:0][PRIO_W-1:0] prio_q;
  logic [LVL_W-1:0]            id_q;

  logic [NSRC-1:0]  raw, keep, raw_vis, pend, fastv;
  logic [N_USER-1:0] user_keep;
  logic [LVL_W-1:0] enc, best;
  logic             fast_any;

  assign raw = {periph_irq, ext_irq, user_irq};

  always_comb begin
    case (mode_q)
      M_ENC6:  user_keep = '0;
      M_ENC5:  user_keep = {{(N_USER-1){1'b0}}, 1'b1};
      default: user_keep = '1;
    endcase
  end

  assign keep    = {{(N_PERIPH+1){1'b1}}, user_keep};
  assign raw_vis = raw & keep;
  assign pend    = raw_vis & mask_q;

  always_comb begin
    case (mode_q)
      M_ENC6:  enc = user_irq;
      M_ENC5:  enc = {user_irq[N_USER-1:1], 1'b0};
      default: enc = '0;
    endcase
  end

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_fast
      assign fastv[g] = prio_q[g][PRIO_W-1];
    end
  endgenerate

  assign fast_any = |(pend & fastv);

  always_comb begin
    best = enc;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i] && !fastv[i] && prio_q[i][LVL_W-1:0] > best)
        best = prio_q[i][LVL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q  <= '0;
      irq_n <= 1'b1;
      fiq_n <= 1'b1;
    end else begin
      id_q  <= best;
      irq_n <= (best == '0);
      fiq_n <= !fast_any;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_INDIV;
      mask_q <= '0;
      prio_q <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_MODE) mode_q <= bus_wdata[1:0];
      if (bus_addr == A_SET)  mask_q <= mask_q | bus_wdata;
      if (bus_addr == A_CLR)  mask_q <= mask_q & ~bus_wdata;
      for (int i = 0; i < NSRC; i++) begin
        if (bus_addr == ADDR_W'(PRIO_BASE + i))
          prio_q[i] <= bus_wdata[PRIO_W-1:0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_MODE:        bus_rdata = {{(NSRC-2){1'b0}}, mode_q};
      A_SET, A_CLR:  bus_rdata = mask_q;
      A_RAW:         bus_rdata = raw_vis;
      A_PEND:        bus_rdata = pend;
      A_ID:          bus_rdata = {{(NSRC-LVL_W){1'b0}}, id_q};
      default: begin
        for (int i = 0; i < NSRC; i++) begin
          if (bus_addr == ADDR_W'(PRIO_BASE + i))
            bus_rdata = {{(NSRC-PRIO_W){1'b0}}, prio_q[i]};
        end
      end
    endcase
  end

  // R2
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_SET) |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));

  // R2
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CLR) |=> ((mask_q & $past(bus_wdata)) == '0));

  // R5
  id_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n |-> (id_q == '0));

  // R9
  enc6_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_ENC6 && user_irq != '0 && !(bus_we && bus_addr == A_MODE))
      |=> (!irq_n && id_q >= $past(user_irq)));

  // R10
  enc5_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_ENC5 && user_irq[N_USER-1:1] != '0) |=> !irq_n);

endmodule

// File: tb/test_irq_merge_ctrl.sv
module test_irq_merge_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  periph_irq = '0;
  logic        ext_irq = 1'b0;
  logic [5:0]  user_irq = '0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [16:0] bus_wdata = '0;
  logic [16:0] bus_rdata;
  logic        irq_n, fiq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic       irq_n;
    logic       fiq_n;
    logic [5:0] id;
    logic [7:0] req;
  } exp_t;
  exp_t q[$];

  irq_merge_ctrl i_irq_merge_ctrl (
    .clk(clk), .rst_n(rst_n), .periph_irq(periph_irq), .ext_irq(ext_irq),
    .user_irq(user_irq), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n), .fiq_n(fiq_n));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [16:0] got, input logic [16:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [16:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [4:0] a, input logic [16:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1 chk(tag, bus_rdata, exp);
  endtask

  task automatic expect_out(input int r, input logic i_n, input logic f_n, input logic [5:0] id);
    exp_t e;
    repeat (2) @(negedge clk);
    e.irq_n = i_n; e.fiq_n = f_n; e.id = id; e.req = 8'(r);
    q.push_back(e);
    rd($sformatf("R%0d identity", r), 5'h05, {11'b0, id});
    repeat (2) @(negedge clk);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (irq_n !== e.irq_n || fiq_n !== e.fiq_n) begin
          errors++;
          $display("FAIL R%0d outputs: got irq_n=%b fiq_n=%b expected irq_n=%b fiq_n=%b",
                   e.req, irq_n, fiq_n, e.irq_n, e.fiq_n);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq_n", {16'b0, irq_n}, 17'd1);
    chk("R1 fiq_n", {16'b0, fiq_n}, 17'd1);
    rd("R1 mode", 5'h00, 17'd0);
    rd("R1 mask", 5'h01, 17'd0);
    rd("R1 id", 5'h05, 17'd0);
    rd("R1 prio", 5'h08 + 5'd7, 17'd0);
    rst_n = 1'b1;
    // R4 priority programming
    wr(5'h08 + 5'd0, 17'h01);
    wr(5'h08 + 5'd1, 17'h00);
    wr(5'h08 + 5'd5, 17'h05);
    wr(5'h08 + 5'd6, 17'h43);
    wr(5'h08 + 5'd7, 17'h0A);
    rd("R4 prio ext", 5'h08 + 5'd6, 17'h43);
    rd("R4 prio periph0", 5'h08 + 5'd7, 17'h0A);
    // R2 set
    wr(5'h01, 17'h000FF);
    rd("R2 mask set", 5'h01, 17'h000FF);
    wr(5'h01, 17'h00000);
    rd("R2 zero write", 5'h02, 17'h000FF);
    // R5 individual arbitration
    user_irq = 6'b100011;
    expect_out(5, 1'b0, 1'b1, 6'd5);
    rd("R3 raw", 5'h03, 17'h023);
    rd("R3 pending", 5'h04, 17'h023);
    // R6 level zero excluded
    user_irq = 6'b000010;
    expect_out(6, 1'b1, 1'b1, 6'd0);
    // R7 fast source
    ext_irq = 1'b1;
    expect_out(7, 1'b1, 1'b0, 6'd0);
    user_irq = 6'b100010;
    expect_out(7, 1'b0, 1'b0, 6'd5);
    periph_irq[0] = 1'b1;
    expect_out(5, 1'b0, 1'b0, 6'd10);
    rd("R3 raw periph", 5'h03, 17'h0E2);
    // R2 clear
    wr(5'h02, 17'h00080);
    rd("R2 mask clear", 5'h01, 17'h0007F);
    expect_out(2, 1'b0, 1'b0, 6'd5);
    rd("R3 pending masked", 5'h04, 17'h062);
    // R11 one-cycle latency
    @(negedge clk);
    user_irq = '0; ext_irq = 1'b0; periph_irq = '0;
    #1 chk("R11 before edge irq_n", {16'b0, irq_n}, 17'd0);
    @(negedge clk);
    #1 chk("R11 after edge irq_n", {16'b0, irq_n}, 17'd1);
    chk("R11 after edge fiq_n", {16'b0, fiq_n}, 17'd1);
    // R8 R9 six-bit encoded mode
    wr(5'h00, 17'd1);
    rd("R8 mode", 5'h00, 17'd1);
    wr(5'h02, 17'h1FFFF);
    user_irq = 6'd7;
    expect_out(9, 1'b0, 1'b1, 6'd7);
    rd("R9 raw hidden", 5'h03, 17'h0);
    rd("R9 pending hidden", 5'h04, 17'h0);
    user_irq = 6'd0;
    expect_out(9, 1'b1, 1'b1, 6'd0);
    wr(5'h01, 17'h00080);
    periph_irq[0] = 1'b1;
    user_irq = 6'd63;
    expect_out(9, 1'b0, 1'b1, 6'd63);
    user_irq = 6'd3;
    expect_out(9, 1'b0, 1'b1, 6'd10);
    periph_irq = '0; user_irq = '0;
    // R10 split mode
    wr(5'h00, 17'd2);
    wr(5'h01, 17'h00001);
    wr(5'h08 + 5'd0, 17'h41);
    user_irq = 6'b000111;
    expect_out(10, 1'b0, 1'b0, 6'd6);
    user_irq = 6'b111110;
    expect_out(10, 1'b0, 1'b1, 6'd62);
    user_irq = 6'b111111;
    rd("R10 raw line0 only", 5'h03, 17'h001);
    user_irq = '0;
    // R8 code 3 acts as individual
    wr(5'h00, 17'd3);
    wr(5'h01, 17'h00020);
    user_irq = 6'b100000;
    expect_out(8, 1'b0, 1'b1, 6'd5);
    rd("R8 mode 3", 5'h00, 17'd3);
    user_irq = '0;
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule